// File: doc/BRIEF.md
# Configuration Register Access Port

This block is the front end of one device's 4 KB configuration space. Each request carries a byte offset, a size (byte, word or DWord), a path (I/O-style or memory-mapped), a write flag and write data. The block decides whether the access is allowed for that region. It then applies little-endian byte lanes to a register file organised as DWords. One cycle after the request, it returns read data and an error flag.

A small set of DWord registers is implemented. `LOW_REGS` of them sit at the bottom of the 256-byte legacy region, and `HIGH_REGS` of them sit from offset 256 upward in the extended region. Other legal offsets behave as empty space. One DWord of the legacy region is the configuration-address register, which refuses any partial access. A per-register write mask protects reserved bits, so software does not need to merge them.

Top module: `cfg_reg_port`

## Requirements
- R1: After reset, `rspValid`, `rspErr` and `rspRdata` are zero, and every implemented register reads as zero.
- R2: Every request with `reqValid` high produces exactly one response with `rspValid` high, on the clock edge after the request edge. `rspErr` is only high together with `rspValid`.
- R3: In offsets 0..255, byte accesses are legal at any offset, word accesses at even offsets and DWord accesses at multiples of 4, on either path. Size codes are 0 byte, 1 word and 2 DWord.
- R4: Size code 3 is illegal. A word at an odd offset is illegal. A DWord whose offset has non-zero bits [1:0] is illegal.
- R5: Offsets 256..4095 are legal only for DWord accesses with `reqPath`=1 (memory-mapped). Any other size, or `reqPath`=0 (I/O), is illegal.
- R6: The DWord at index `ADDR_IDX` (default offset 8..11) accepts only DWord accesses. Byte and word accesses to it are illegal.
- R7: An illegal access changes no register. Its response has `rspRdata`=0xFFFFFFFF and `rspErr`=1, and `rspErr` is high only in that one response cycle.
- R8: Lanes are little-endian. A write places `reqWdata[7:0]` in byte `offset[1:0]` and the next bytes above it. A read returns the lane at `offset[1:0]` in bits [7:0] and the lanes above it in the bits above, with bits beyond the access size zero.
- R9: Only bits set in a register's write mask change on a write, and masked-off bits read as zero. The address register's mask is `ADDR_MASK` (default 0x80FFFFFC). All other registers use `GEN_MASK` (default 0xFFFF7FF3).
- R10: A legal access to an unimplemented DWord raises no error, reads zero and changes nothing. A legal write's response data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| reqValid | input | 1 | Request strobe, one cycle per access |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqOffset | input | 12 | Byte offset within the 4 KB space |
| reqSize | input | 2 | 0 byte, 1 word, 2 DWord, 3 invalid |
| reqPath | input | 1 | 0 I/O-style, 1 memory-mapped |
| reqWdata | input | 32 | Write data, least significant byte first |
| rspValid | output | 1 | Response strobe |
| rspRdata | output | 32 | Read data, or all ones on error |
| rspErr | output | 1 | Disallowed-access flag |

## Verification
Each response is due at the first clock edge after the request edge, and the register update for a write takes effect at that same edge. The bench drives a request on a falling edge, removes it on the next falling edge, and samples the response then. It checks one further falling edge later that the strobe and error flag have dropped. Register contents are never probed directly. Every write is followed in the sweep by reads through the ports, and those reads are compared with a bench model built from the lane, mask and legality rules.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2,
    SZ_BAD   = 2'd3
  } accSize_e;

  // strobes from decode to datapath
  typedef struct packed {
    logic       valid;
    logic       err;
    logic       wrEn;
    logic       rdEn;
    logic       hit;
    logic [9:0] dwIdx;
    logic [1:0] shift;
    logic [3:0] laneEn;
    accSize_e   size;
  } ctrlStrobe_t;

  localparam logic [9:0] HIGH_BASE = 10'd64;

endpackage

// File: rtl/cfg_ctrl.sv
module cfg_ctrl
  import cfg_port_pkg::*;
#(
  parameter int LOW_REGS  = 8,
  parameter int HIGH_REGS = 4,
  parameter int ADDR_IDX  = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic [11:0] reqOffset,
  input  accSize_e    reqSize,
  input  logic        reqPath,
  output ctrlStrobe_t st
);

  localparam logic [9:0] LOW_END  = 10'(LOW_REGS);
  localparam logic [9:0] HIGH_END = 10'(64 + HIGH_REGS);
  localparam logic [9:0] ADDR_DW  = 10'(ADDR_IDX);

  logic [9:0] dwIdx;
  logic       inHigh, misAligned, badAcc, hit;
  logic [3:0] laneBase;

  always_comb begin
    dwIdx      = reqOffset[11:2];
    inHigh     = reqOffset[11:8] != 4'd0;
    misAligned = (reqSize == SZ_WORD && reqOffset[0]) ||
                 (reqSize == SZ_DWORD && reqOffset[1:0] != 2'd0);
    badAcc     = (reqSize == SZ_BAD) || misAligned ||
                 (inHigh && (reqSize != SZ_DWORD || !reqPath)) ||
                 (!inHigh && dwIdx == ADDR_DW && reqSize != SZ_DWORD);
    hit        = (dwIdx < LOW_END) || (dwIdx >= HIGH_BASE && dwIdx < HIGH_END);
    unique case (reqSize)
      SZ_BYTE:  laneBase = 4'b0001;
      SZ_WORD:  laneBase = 4'b0011;
      default:  laneBase = 4'b1111;
    endcase
    st.valid  = reqValid;
    st.err    = reqValid && badAcc;
    st.wrEn   = reqValid && reqWrite && !badAcc && hit;
    st.rdEn   = reqValid && !reqWrite && !badAcc;
    st.hit    = hit;
    st.dwIdx  = dwIdx;
    st.shift  = reqOffset[1:0];
    st.laneEn = laneBase << reqOffset[1:0];
    st.size   = reqSize;
  end

  // R8
  wr_lanes_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.wrEn |-> ($countones(st.laneEn) inside {1, 2, 4}));

  // R5
  high_full_dword_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.wrEn && st.dwIdx >= HIGH_BASE) |-> st.laneEn == 4'hF);

endmodule

// File: rtl/cfg_data.sv
module cfg_data
  import cfg_port_pkg::*;
#(
  parameter int          LOW_REGS  = 8,
  parameter int          HIGH_REGS = 4,
  parameter int          ADDR_IDX  = 2,
  parameter logic [31:0] ADDR_MASK = 32'h80FF_FFFC,
  parameter logic [31:0] GEN_MASK  = 32'hFFFF_7FF3
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t st,
  input  logic [31:0] wdata,
  output logic        rspValid,
  output logic [31:0] rspRdata,
  output logic        rspErr
);

  localparam int NREG  = LOW_REGS + HIGH_REGS;
  localparam int SLOTW = $clog2(NREG);

  logic [NREG-1:0][31:0] regFile;
  logic [NREG-1:0][31:0] maskArr;
  logic [9:0]            slotWide;
  logic [SLOTW-1:0]      slot;
  logic [31:0]           laneBits, wShift, cur, sizeMask, rdNext;

  for (genvar g = 0; g < NREG; g++) begin : gMask
    assign maskArr[g] = (g == ADDR_IDX) ? ADDR_MASK : GEN_MASK;
  end

  always_comb begin
    slotWide = (st.dwIdx < 10'(LOW_REGS)) ? st.dwIdx
                                         : st.dwIdx - HIGH_BASE + 10'(LOW_REGS);
    slot     = slotWide[SLOTW-1:0];
    laneBits = {{8{st.laneEn[3]}}, {8{st.laneEn[2]}}, {8{st.laneEn[1]}}, {8{st.laneEn[0]}}};
    wShift   = wdata << {st.shift, 3'b000};
    cur      = st.hit ? (regFile[slot] & maskArr[slot]) : 32'd0;
    unique case (st.size)
      SZ_BYTE: sizeMask = 32'h0000_00FF;
      SZ_WORD: sizeMask = 32'h0000_FFFF;
      default: sizeMask = 32'hFFFF_FFFF;
    endcase
    if (st.err)       rdNext = 32'hFFFF_FFFF;
    else if (st.rdEn) rdNext = (cur >> {st.shift, 3'b000}) & sizeMask;
    else              rdNext = 32'd0;
  end

  for (genvar g = 0; g < NREG; g++) begin : gReg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) regFile[g] <= 32'd0;
      else if (st.wrEn && slot == SLOTW'(g))
        regFile[g] <= (regFile[g] & ~(laneBits & maskArr[g])) |
                      (wShift & laneBits & maskArr[g]);
    end

    // R9
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
      (regFile[g] & ~maskArr[g]) == 32'd0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspErr   <= 1'b0;
      rspRdata <= 32'd0;
    end else begin
      rspValid <= st.valid;
      rspErr   <= st.err;
      rspRdata <= rdNext;
    end
  end

  // R7
  no_write_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !st.wrEn |=> $stable(regFile));

  // R7
  err_ones_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspErr |-> rspRdata == 32'hFFFF_FFFF);

endmodule

// File: rtl/cfg_reg_port.sv
module cfg_reg_port
  import cfg_port_pkg::*;
#(
  parameter int          LOW_REGS  = 8,
  parameter int          HIGH_REGS = 4,
  parameter int          ADDR_IDX  = 2,
  parameter logic [31:0] ADDR_MASK = 32'h80FF_FFFC,
  parameter logic [31:0] GEN_MASK  = 32'hFFFF_7FF3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic [11:0] reqOffset,
  input  logic [1:0]  reqSize,
  input  logic        reqPath,
  input  logic [31:0] reqWdata,
  output logic        rspValid,
  output logic [31:0] rspRdata,
  output logic        rspErr
);

  ctrlStrobe_t st;

  cfg_ctrl #(
    .LOW_REGS(LOW_REGS), .HIGH_REGS(HIGH_REGS), .ADDR_IDX(ADDR_IDX)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqOffset(reqOffset), .reqSize(accSize_e'(reqSize)), .reqPath(reqPath),
    .st(st)
  );

  cfg_data #(
    .LOW_REGS(LOW_REGS), .HIGH_REGS(HIGH_REGS), .ADDR_IDX(ADDR_IDX),
    .ADDR_MASK(ADDR_MASK), .GEN_MASK(GEN_MASK)
  ) data_i (
    .clk(clk), .rstN(rstN), .st(st), .wdata(reqWdata),
    .rspValid(rspValid), .rspRdata(rspRdata), .rspErr(rspErr)
  );

  // R2
  err_with_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspErr |-> rspValid);

  // R2
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  // R8
  byte_read_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite && reqSize == 2'd0) |=> (rspErr || rspRdata[31:8] == 24'd0));

endmodule

// File: tb/cfg_reg_port_tb_top.sv
module cfg_reg_port_tb_top;

  localparam int LOW_REGS = 8;
  localparam int HIGH_REGS = 4;
  localparam int ADDR_IDX = 2;
  localparam int NREG = LOW_REGS + HIGH_REGS;
  localparam logic [31:0] ADDR_MASK = 32'h80FF_FFFC;
  localparam logic [31:0] GEN_MASK  = 32'hFFFF_7FF3;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0, reqPath = 1'b0;
  logic [11:0] reqOffset = 12'd0;
  logic [1:0] reqSize = 2'd0;
  logic [31:0] reqWdata = 32'd0;
  logic rspValid, rspErr;
  logic [31:0] rspRdata;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [31:0] model [NREG];

  always #10 clk = ~clk;

  cfg_reg_port dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqOffset(reqOffset), .reqSize(reqSize), .reqPath(reqPath),
    .reqWdata(reqWdata), .rspValid(rspValid), .rspRdata(rspRdata), .rspErr(rspErr)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int slotOf(int off);
    int d = off / 4;
    if (d < LOW_REGS) return d;
    if (d >= 64 && d < 64 + HIGH_REGS) return LOW_REGS + d - 64;
    return -1;
  endfunction

  function automatic bit isBad(int off, int sz, bit path);
    if (sz == 3) return 1;
    if (sz == 1 && (off % 2) != 0) return 1;
    if (sz == 2 && (off % 4) != 0) return 1;
    if (off >= 256 && (sz != 2 || !path)) return 1;
    if (off < 256 && off / 4 == ADDR_IDX && sz != 2) return 1;
    return 0;
  endfunction

  function automatic logic [31:0] maskOf(int s);
    return (s == ADDR_IDX) ? ADDR_MASK : GEN_MASK;
  endfunction

  task automatic doAcc(input bit wr, input int off, input int sz, input bit path,
                       input logic [31:0] d, input string req);
    bit bad = isBad(off, sz, path);
    int s = slotOf(off);
    int sh = (off % 4) * 8;
    logic [31:0] sizeM = (sz == 0) ? 32'hFF : (sz == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
    logic [31:0] expD;
    logic [31:0] lanes;
    if (bad) expD = 32'hFFFF_FFFF;
    else if (wr || s < 0) expD = 32'd0;
    else expD = (model[s] >> sh) & sizeM;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqOffset = 12'(off); reqSize = 2'(sz);
    reqPath = path; reqWdata = d;
    @(negedge clk);
    reqValid = 1'b0;
    if (!bad && wr && s >= 0) begin
      lanes = (sizeM << sh) & maskOf(s);
      model[s] = (model[s] & ~lanes) | ((d << sh) & lanes);
    end
    check(rspValid == 1'b1, "R2 response strobe", 32'(rspValid), 32'd1);
    check(rspErr == bad, bad ? "R7 error flag" : "R3 no error", 32'(rspErr), 32'(bad));
    check(rspRdata == expD, req, rspRdata, expD);
    @(negedge clk);
    check(rspValid == 1'b0 && rspErr == 1'b0, "R7 single-cycle flag", 32'({rspValid, rspErr}), 32'd0);
  endtask

  initial begin
    #(20ns * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NREG; i++) model[i] = 32'd0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(rspValid == 0 && rspErr == 0 && rspRdata == 0, "R1 reset outputs", rspRdata, 32'd0);
    rstN = 1'b1;
    for (int i = 0; i < LOW_REGS; i++) doAcc(0, i * 4, 2, 1, 0, "R1 low reg reset");
    for (int i = 0; i < HIGH_REGS; i++) doAcc(0, 256 + i * 4, 2, 1, 0, "R1 high reg reset");

    // low region sweep: R3 R4 R6 R8 R9 R10
    for (int off = 0; off < 36; off++)
      for (int sz = 0; sz < 4; sz++)
        for (int p = 0; p < 2; p++) begin
          doAcc(1, off, sz, p[0], 32'(off * 32'h0101_0101) ^ 32'(sz * 32'h1357_9BDF) ^ 32'(p * 32'hFFFF_FFFF),
                "R10 write response");
          doAcc(0, off, sz, p[0], 0, "R8 lane read");
          doAcc(0, (off / 4) * 4, 2, 1, 0, "R9 masked dword read");
        end

    // extended region sweep: R5 R9 R10
    for (int off = 256; off < 276; off++)
      for (int sz = 0; sz < 4; sz++)
        for (int p = 0; p < 2; p++) begin
          doAcc(1, off, sz, p[0], 32'hA5C3_0000 + 32'(off * 7 + sz), "R5 extended write");
          doAcc(0, (off / 4) * 4, 2, p[0], 0, "R5 extended read");
        end

    // far offsets, unimplemented: R10
    doAcc(1, 512, 2, 1, 32'hDEAD_BEEF, "R10 unimplemented write");
    doAcc(0, 512, 2, 1, 0, "R10 unimplemented read");
    doAcc(0, 4092, 2, 1, 0, "R10 top dword read");
    doAcc(0, 4095, 0, 1, 0, "R5 top byte rejected");

    // final readback: R7 nothing disturbed
    for (int i = 0; i < LOW_REGS; i++) doAcc(0, i * 4, 2, 0, 0, "R7 final low readback");
    for (int i = 0; i < HIGH_REGS; i++) doAcc(0, 256 + i * 4, 2, 1, 0, "R7 final high readback");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule